// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits on the device side of a four-bank synchronous DRAM command bus. On every rising clock edge where clock-enable is high and chip-select is asserted, it reads the command strobes, the bank-select bits and the address bus. It recognises three commands: mode-register load, bank activate and bank precharge. It keeps an idle or active flag and the open row for each bank. It also holds the mode register contents.

The block enforces the recovery windows of the device. After an accepted mode-register load, a fixed number of cycles follow in which no command is taken. After a precharge, each affected bank has its own recovery counter, and an activate to that bank is refused until the counter runs out. A rejected command changes no state. Instead, it sets exactly one bit of a registered error vector in the cycle after the command. Read and write data, refresh and burst handling are outside this block.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Commands are decoded from (cs_n, ras_n, cas_n, we_n). 0000 is mode load, 0011 is activate and 0010 is precharge. Every other pattern is ignored. When cke is low or cs_n is high, nothing changes and err_flags reads 0 in the next cycle.
- R2: An accepted activate sets bank_active[ba] and stores addr as that bank's open row, at open_row[ba*ROWW +: ROWW]. Both are visible in the cycle after the command.
- R3: A precharge with addr[10] low clears only bank_active[ba]. A precharge with addr[10] high clears every bank, whatever ba holds.
- R4: An accepted mode load writes {ba, addr} (14 bits, ba in the top two) into mode_reg and sets mode_valid. mode_valid then stays high until reset.
- R5: A mode load while any bank is active sets err_flags[4] and leaves mode_reg unchanged.
- R6: For TRSC (default 2) cycles after an accepted mode load, any mode load, activate or precharge is refused. Such a command sets err_flags[0] and changes no state.
- R7: A precharge starts a TRP (default 3) cycle recovery window for each bank it closes. An activate to a bank inside its window sets err_flags[2], and the bank stays idle. bank_recovering shows each bank's window.
- R8: An activate issued before any accepted mode load sets err_flags[1] and opens nothing.
- R9: An activate to a bank that is already active sets err_flags[3] and leaves its open row unchanged.
- R10: Synchronous reset clears all bank flags, open rows, mode_reg, mode_valid, the timers and err_flags. err_flags reports at most one bit per command, one cycle after the command. Priority order is bit 0, then bit 1, then bit 2, then bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low means no command |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row address / mode value / addr[10] all-bank select |
| bank_active | output | 4 | Per-bank active flag |
| bank_recovering | output | 4 | Per-bank precharge recovery window in progress |
| open_row | output | 48 | Open row of each bank, packed by bank index |
| mode_reg | output | 14 | Mode register contents |
| mode_valid | output | 1 | A mode load has been accepted since reset |
| err_flags | output | 5 | One-hot rejection cause for the previous command |

## Verification
The assertions assume that reset is held for at least one clock edge before checking starts. They also assume that the command inputs are settled at every rising edge. The bench meets both by driving inputs only on falling edges and by releasing reset on a falling edge. The properties about mode-register changes assume that a mode load carries a value different from the current contents. Without that, an accepted load would be invisible to them. The stimulus therefore always loads a new value. Beyond this, no restriction is placed on the command stream. Illegal sequences are issued on purpose, and the checker is expected to accept them as long as the design refuses them.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_MODE = 2'd1,
    CMD_OPEN = 2'd2,
    CMD_CLOSE = 2'd3
  } cmd_e;

  localparam int NERR      = 5;
  localparam int E_LOCKOUT = 0;
  localparam int E_NOINIT  = 1;
  localparam int E_RECOVER = 2;
  localparam int E_DOUBLE  = 3;
  localparam int E_BUSY    = 4;
endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
  import sdc_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NONE;
    if (cke && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MODE;
        3'b011:  cmd = CMD_OPEN;
        3'b010:  cmd = CMD_CLOSE;
        default: cmd = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sdc_mode_ctl.sv
module sdc_mode_ctl #(
  parameter int MW   = 14,
  parameter int TRSC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [MW-1:0] value,
  output logic [MW-1:0] mode_q,
  output logic          valid_q,
  output logic          locked
);
  localparam int CW = $clog2(TRSC + 1);
  logic [CW-1:0] lock_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      valid_q  <= 1'b0;
      lock_cnt <= '0;
    end else begin
      if (load) begin
        mode_q   <= value;
        valid_q  <= 1'b1;
        lock_cnt <= CW'(TRSC);
      end else if (lock_cnt != '0) begin
        lock_cnt <= lock_cnt - 1'b1;
      end
    end
  end

  assign locked = (lock_cnt != '0);
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank #(
  parameter int ROWW = 12,
  parameter int TRP  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            open_en,
  input  logic            close_en,
  input  logic [ROWW-1:0] row_in,
  output logic            active_q,
  output logic [ROWW-1:0] row_q,
  output logic            recovering
);
  localparam int CW = $clog2(TRP + 1);
  logic [CW-1:0] rec_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      row_q    <= '0;
      rec_cnt  <= '0;
    end else begin
      if (open_en) begin
        active_q <= 1'b1;
        row_q    <= row_in;
      end else if (close_en) begin
        active_q <= 1'b0;
      end
      if (close_en)
        rec_cnt <= CW'(TRP);
      else if (rec_cnt != '0)
        rec_cnt <= rec_cnt - 1'b1;
    end
  end

  assign recovering = (rec_cnt != '0);
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdc_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int ROWW  = 12,
  parameter int TRP   = 3,
  parameter int TRSC  = 2,
  parameter int AP    = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cke,
  input  logic                        cs_n,
  input  logic                        ras_n,
  input  logic                        cas_n,
  input  logic                        we_n,
  input  logic [$clog2(NBANK)-1:0]    ba,
  input  logic [ROWW-1:0]             addr,
  output logic [NBANK-1:0]            bank_active,
  output logic [NBANK-1:0]            bank_recovering,
  output logic [NBANK*ROWW-1:0]       open_row,
  output logic [ROWW+$clog2(NBANK)-1:0] mode_reg,
  output logic                        mode_valid,
  output logic [NERR-1:0]             err_flags
);
  localparam int BAW = $clog2(NBANK);
  localparam int MW  = ROWW + BAW;

  cmd_e             cmd;
  logic             locked;
  logic             any_active;
  logic             mode_load;
  logic [NERR-1:0]  err_nx;
  logic [NBANK-1:0] open_en, close_en;

  sdc_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  assign any_active = |bank_active;

  always_comb begin
    err_nx    = '0;
    mode_load = 1'b0;
    if (cmd != CMD_NONE && locked) begin
      err_nx[E_LOCKOUT] = 1'b1;
    end else begin
      case (cmd)
        CMD_MODE: begin
          if (any_active) err_nx[E_BUSY] = 1'b1;
          else            mode_load      = 1'b1;
        end
        CMD_OPEN: begin
          if (!mode_valid)              err_nx[E_NOINIT]  = 1'b1;
          else if (bank_recovering[ba]) err_nx[E_RECOVER] = 1'b1;
          else if (bank_active[ba])     err_nx[E_DOUBLE]  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  sdc_mode_ctl #(.MW(MW), .TRSC(TRSC)) u_mode (
    .clk(clk), .rst(rst), .load(mode_load), .value({ba, addr}),
    .mode_q(mode_reg), .valid_q(mode_valid), .locked(locked)
  );

  generate
    for (genvar i = 0; i < NBANK; i++) begin : g_bank
      logic hit;
      assign hit = (ba == BAW'(i));
      assign open_en[i]  = (cmd == CMD_OPEN) && hit && (err_nx == '0);
      assign close_en[i] = (cmd == CMD_CLOSE) && !locked && (addr[AP] || hit);
      sdc_bank #(.ROWW(ROWW), .TRP(TRP)) u_bank (
        .clk(clk), .rst(rst), .open_en(open_en[i]), .close_en(close_en[i]),
        .row_in(addr), .active_q(bank_active[i]),
        .row_q(open_row[i*ROWW +: ROWW]), .recovering(bank_recovering[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) err_flags <= '0;
    else     err_flags <= err_nx;
  end
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
  parameter int NBANK = 4,
  parameter int ROWW  = 12,
  parameter int NE    = 5
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           cke,
  input logic                           cs_n,
  input logic [NBANK-1:0]               bank_active,
  input logic [NBANK-1:0]               bank_recovering,
  input logic [ROWW+$clog2(NBANK)-1:0]  mode_reg,
  input logic                           mode_valid,
  input logic [NE-1:0]                  err_flags
);
  // R1: an idle bus leaves every piece of state alone
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!cke || cs_n) |=> ($stable(bank_active) && $stable(mode_reg) && err_flags == '0));

  // R10: at most one rejection cause per command
  p_err_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(err_flags));

  // R8: nothing opens before the mode register was loaded
  p_open_needs_mode_r8: assert property (@(posedge clk) disable iff (rst)
    ((bank_active & ~$past(bank_active)) != '0) |-> $past(mode_valid));

  // R7: a bank never opens out of its recovery window
  p_open_after_recovery_r7: assert property (@(posedge clk) disable iff (rst)
    (bank_active & ~$past(bank_active) & $past(bank_recovering)) == '0);

  // R5: mode register only changes while all banks were idle
  p_mode_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_reg) |-> ($past(bank_active) == '0));

  // R6: the two lockout cycles after a mode load change nothing
  p_lockout_first_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_reg) |=> ($stable(bank_active) && $stable(mode_reg)));
  p_lockout_second_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_reg) |-> ##2 ($stable(bank_active) && $stable(mode_reg)));
endmodule

bind sdram_cmd_tracker sdc_checker #(.NBANK(NBANK), .ROWW(ROWW), .NE(sdc_pkg::NERR)) i_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .bank_active(bank_active),
  .bank_recovering(bank_recovering), .mode_reg(mode_reg), .mode_valid(mode_valid),
  .err_flags(err_flags)
);

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, RW = 12, TRP = 3, TRSC = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [RW-1:0] addr = '0;
  logic [NB-1:0] bank_active, bank_recovering;
  logic [NB*RW-1:0] open_row;
  logic [13:0] mode_reg;
  logic mode_valid;
  logic [4:0] err_flags;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_tracker i_sdram_cmd_tracker (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .bank_active(bank_active),
    .bank_recovering(bank_recovering), .open_row(open_row), .mode_reg(mode_reg),
    .mode_valid(mode_valid), .err_flags(err_flags)
  );

  typedef struct {
    logic [NB-1:0] act;
    logic [4:0]    err;
    logic [13:0]   mode;
    logic          mv;
    int            bank;
    logic [RW-1:0] row;
    string         tag;
  } exp_t;
  exp_t q[$];

  // reference state
  logic [NB-1:0] m_act = '0;
  logic [RW-1:0] m_row [NB];
  int m_rec [NB];
  int m_lock = 0;
  logic m_mv = 0;
  logic [13:0] m_mode = '0;

  task automatic issue(input string tag, input logic k, c, r, ca, w,
                       input logic [1:0] b, input logic [RW-1:0] a);
    exp_t e;
    int nrec [NB];
    int nlock;
    logic is_mode, is_open, is_close;
    @(negedge clk);
    cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    is_mode  = k && !c && {r, ca, w} == 3'b000;
    is_open  = k && !c && {r, ca, w} == 3'b011;
    is_close = k && !c && {r, ca, w} == 3'b010;
    e.err = '0;
    for (int i = 0; i < NB; i++) nrec[i] = (m_rec[i] > 0) ? m_rec[i] - 1 : 0;
    nlock = (m_lock > 0) ? m_lock - 1 : 0;
    if ((is_mode || is_open || is_close) && m_lock > 0) e.err[0] = 1'b1;
    else if (is_mode) begin
      if (m_act != '0) e.err[4] = 1'b1;
      else begin m_mode = {b, a}; m_mv = 1'b1; nlock = TRSC; end
    end else if (is_open) begin
      if (!m_mv)               e.err[1] = 1'b1;
      else if (m_rec[b] > 0)   e.err[2] = 1'b1;
      else if (m_act[b])       e.err[3] = 1'b1;
      else begin m_act[b] = 1'b1; m_row[b] = a; end
    end else if (is_close) begin
      for (int i = 0; i < NB; i++)
        if (a[10] || b == 2'(i)) begin m_act[i] = 1'b0; nrec[i] = TRP; end
    end
    for (int i = 0; i < NB; i++) m_rec[i] = nrec[i];
    m_lock = nlock;
    e.act = m_act; e.mode = m_mode; e.mv = m_mv; e.bank = int'(b);
    e.row = m_row[b]; e.tag = tag;
    @(posedge clk); #1;
    q.push_back(e);
  endtask

  task automatic nop(input string tag);
    issue(tag, 1, 1, 0, 1, 1, 2'd0, '0);
  endtask
  task automatic mode_load(input string tag, input logic [1:0] b, input logic [RW-1:0] a);
    issue(tag, 1, 0, 0, 0, 0, b, a);
  endtask
  task automatic open_bank(input string tag, input logic [1:0] b, input logic [RW-1:0] a);
    issue(tag, 1, 0, 0, 1, 1, b, a);
  endtask
  task automatic close_bank(input string tag, input logic [1:0] b, input logic all);
    issue(tag, 1, 0, 0, 1, 0, b, all ? 12'h400 : 12'h000);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        logic ok;
        e = q.pop_front();
        total++;
        ok = (bank_active === e.act) && (err_flags === e.err) &&
             (mode_reg === e.mode) && (mode_valid === e.mv);
        if (e.act[e.bank] && open_row[e.bank*RW +: RW] !== e.row) ok = 1'b0;
        if (!ok) begin
          bad++;
          $display("FAIL %s: act=%b err=%b mode=%h mv=%b row=%h expected act=%b err=%b mode=%h mv=%b row=%h",
                   e.tag, bank_active, err_flags, mode_reg, mode_valid,
                   open_row[e.bank*RW +: RW], e.act, e.err, e.mode, e.mv, e.row);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: expected completion, run hung");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin m_row[i] = '0; m_rec[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    total++;  // R10 reset state
    if (bank_active !== '0 || err_flags !== '0 || mode_reg !== '0 || mode_valid !== 1'b0) begin
      bad++;
      $display("FAIL R10: act=%b err=%b mode=%h mv=%b expected all zero",
               bank_active, err_flags, mode_reg, mode_valid);
    end
    nop("R1 idle");
    open_bank("R8 open before mode", 2'd1, 12'h111);
    mode_load("R4 first mode load", 2'd2, 12'h123);
    open_bank("R6 lockout open", 2'd1, 12'h222);
    close_bank("R6 lockout close", 2'd0, 1'b1);
    open_bank("R2 open bank1", 2'd1, 12'hABC);
    open_bank("R9 reopen bank1", 2'd1, 12'h333);
    mode_load("R5 mode while active", 2'd1, 12'h0F0);
    open_bank("R2 open bank3", 2'd3, 12'h555);
    close_bank("R3 close bank1 only", 2'd1, 1'b0);
    open_bank("R7 recovery 1", 2'd1, 12'h777);
    open_bank("R7 recovery 2", 2'd1, 12'h777);
    open_bank("R7 recovery 3", 2'd1, 12'h777);
    open_bank("R7 after recovery", 2'd1, 12'h778);
    issue("R1 cke low", 0, 0, 0, 1, 1, 2'd0, 12'h999);
    issue("R1 cs high", 1, 1, 0, 0, 0, 2'd0, 12'h999);
    issue("R1 other pattern", 1, 0, 1, 0, 1, 2'd0, 12'h999);
    close_bank("R3 close all", 2'd0, 1'b1);
    open_bank("R7 bank0 recovering", 2'd0, 12'h010);
    nop("R1 gap");
    nop("R1 gap");
    nop("R1 gap");
    mode_load("R4 second mode load", 2'd1, 12'h0A5);
    nop("R6 lockout nop");
    mode_load("R6 lockout mode", 2'd3, 12'hFFF);
    open_bank("R2 open bank0 after lockout", 2'd0, 12'h0EE);
    nop("R2 hold");
    nop("R1 drain");
    repeat (3) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule